// File: doc/BRIEF.md
# Serial Program Address Sequencer

This block holds the program counter for one instruction memory chip in a bit-serial calculator system. An arithmetic controller steps every chip through a sixteen-state instruction cycle and shares the state number with all of them. Each chip samples one serial control line once per state. The first three states carry command flags: load, condition and hold. Ten states then carry a branch address, least significant bit first. The last three carry a chip-select field. At the end of the last state the sequencer loads, holds or increments its counter.

During the following cycle the sequencer shifts the 13-bit word at its counter out on a serial line, one bit per state. It does so only when its stored chip-select value matches the value fixed for this chip by parameter. Up to eight such chips can sit on the same control and instruction lines, and one address space spans them. The memory contents come from a fill function, so a bench can predict every word.

Top module: `prog_seq`

## Requirements
- R1: While `rstN` is low, `pcOut` is 0 and `csOut` is 0. This holds at once and does not wait for a clock edge.
- R2: The bit sampled in state 3+k is address bit k (k = 0..9). The bit sampled in state 13+j is chip-select bit j (j = 0..2), so the chip-select MSB arrives in state 15.
- R3: If the bit in state 0 (load) is 1 and the bit in state 1 (condition) is 0, then after the clock edge that ends state 15 `pcOut` equals the frame's address field and `csOut` equals the frame's chip-select field.
- R4: If load is 1 and condition is 1, the branch is cancelled. The counter then holds or steps as if load were 0, and `csOut` keeps its value.
- R5: Without a taken load, a 1 in state 2 (hold) leaves `pcOut` and `csOut` unchanged at the end of the cycle.
- R6: Without a taken load or a hold, `pcOut` increases by one at the end of the cycle and wraps from 0x3FF to 0x000. `csOut` is unchanged, and the frame's address and chip-select bits are ignored.
- R7: A taken load has priority over hold in the same frame.
- R8: `pcOut` and `csOut` change only at the clock edge that ends state 15.
- R9: When `csOut` equals `CHIP_ID`, `wordOut` during state k (k = 0..12) is bit k of the word at `pcOut`, and it is 0 in states 13 to 15.
- R10: When `csOut` differs from `CHIP_ID`, `wordOut` is 0 in every state.
- R11: The word at address a is (a * `ROM_MULT` + `ROM_SEED`) mod 2^13. The defaults are 37 and 0x0A5.
- R12: A frame with 1 in state 0 and 0 in all other states leaves `pcOut` = 0x000 and `csOut` = 0, whatever the previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | State-time clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stateIdx | input | 4 | Current state number within the instruction cycle, 0..15 |
| ctlBit | input | 1 | Serial control line, sampled once per state |
| wordOut | output | 1 | Serial instruction bit for the current state |
| pcOut | output | 10 | Program counter |
| csOut | output | 3 | Stored chip-select value |

## Verification
A load and a hold can be requested in the same frame. A load can also be requested together with its own cancelling condition flag. The table provokes both pairs: load with hold must land on the branch address, and load with condition and hold must keep the counter where it is. The bench judges each frame by comparing the counter after the state-15 edge with the expected value. It also checks every serial bit of the following cycle against the fill function, including a cycle where an asymmetric chip-select value deselects the chip.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
  localparam int PC_W       = 10;
  localparam int CS_W       = 3;
  localparam int WORD_W     = 13;
  localparam int FLAG_N     = 3;
  localparam int ADDR_FIRST = FLAG_N;
  localparam int CS_FIRST   = ADDR_FIRST + PC_W;
  localparam int STATE_N    = CS_FIRST + CS_W;
  localparam int STATE_W    = $clog2(STATE_N);
  localparam int PC_IDX_W   = $clog2(PC_W);
  localparam int CS_IDX_W   = $clog2(CS_W);
  localparam int ST_LOAD    = 0;
  localparam int ST_COND    = 1;
  localparam int ST_HOLD    = 2;

  typedef struct packed {
    logic                capLoad;
    logic                capCond;
    logic                capHold;
    logic                capAddr;
    logic                capCs;
    logic                commit;
    logic [PC_IDX_W-1:0] addrIdx;
    logic [CS_IDX_W-1:0] csIdx;
  } seqStrb_t;
endpackage

// File: rtl/prog_seq_ctrl.sv
module prog_seq_ctrl
  import prog_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [STATE_W-1:0] stateIdx,
  output seqStrb_t           strb
);
  localparam logic [STATE_W-1:0] S_LOAD = STATE_W'(ST_LOAD);
  localparam logic [STATE_W-1:0] S_COND = STATE_W'(ST_COND);
  localparam logic [STATE_W-1:0] S_HOLD = STATE_W'(ST_HOLD);
  localparam logic [STATE_W-1:0] S_ADDR = STATE_W'(ADDR_FIRST);
  localparam logic [STATE_W-1:0] S_CS   = STATE_W'(CS_FIRST);
  localparam logic [STATE_W-1:0] S_LAST = STATE_W'(STATE_N - 1);

  logic [STATE_W-1:0] addrOff;
  logic [STATE_W-1:0] csOff;

  assign addrOff = stateIdx - S_ADDR;
  assign csOff   = stateIdx - S_CS;

  always_comb begin
    strb.capLoad = (stateIdx == S_LOAD);
    strb.capCond = (stateIdx == S_COND);
    strb.capHold = (stateIdx == S_HOLD);
    strb.capAddr = (stateIdx >= S_ADDR) && (stateIdx < S_CS);
    strb.capCs   = (stateIdx >= S_CS);
    strb.commit  = (stateIdx == S_LAST);
    strb.addrIdx = PC_IDX_W'(addrOff);
    strb.csIdx   = CS_IDX_W'(csOff);
  end

  // R2
  capture_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.capLoad, strb.capCond, strb.capHold, strb.capAddr, strb.capCs}));
endmodule

// File: rtl/prog_seq_data.sv
module prog_seq_data
  import prog_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            ctlBit,
  input  seqStrb_t        strb,
  output logic [PC_W-1:0] pcQ,
  output logic [CS_W-1:0] csQ
);
  logic            loadQ, condQ, holdQ;
  logic [PC_W-1:0] addrQ, addrCur;
  logic [CS_W-1:0] csShQ, csCur;
  logic            taken;

  always_comb begin
    addrCur = addrQ;
    csCur   = csShQ;
    if (strb.capAddr) addrCur[strb.addrIdx] = ctlBit;
    if (strb.capCs)   csCur[strb.csIdx]     = ctlBit;
  end

  assign taken = loadQ && !condQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadQ <= 1'b0;
      condQ <= 1'b0;
      holdQ <= 1'b0;
      addrQ <= '0;
      csShQ <= '0;
      pcQ   <= '0;
      csQ   <= '0;
    end else begin
      if (strb.capLoad) loadQ <= ctlBit;
      if (strb.capCond) condQ <= ctlBit;
      if (strb.capHold) holdQ <= ctlBit;
      addrQ <= addrCur;
      csShQ <= csCur;
      if (strb.commit) begin
        if (taken) begin
          pcQ <= addrCur;
          csQ <= csCur;
        end else if (!holdQ) begin
          pcQ <= pcQ + 1'b1;
        end
      end
    end
  end

  // R8
  frozen_mid_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(pcQ) && $stable(csQ)));
  // R3
  load_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && loadQ && !condQ) |=> (pcQ == $past(addrCur)));
  // R5
  hold_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && holdQ && !(loadQ && !condQ)) |=> ($stable(pcQ) && $stable(csQ)));
  // R6
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !holdQ && !(loadQ && !condQ)) |=> (pcQ == $past(pcQ) + 1'b1));
endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import prog_seq_pkg::*;
#(
  parameter int CHIP_ID  = 0,
  parameter int ROM_MULT = 37,
  parameter int ROM_SEED = 'h0A5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  stateIdx,
  input  logic        ctlBit,
  output logic        wordOut,
  output logic [9:0]  pcOut,
  output logic [2:0]  csOut
);
  localparam logic [CS_W-1:0]    MY_CS   = CS_W'(CHIP_ID);
  localparam logic [STATE_W-1:0] WORD_ST = STATE_W'(WORD_W);

  seqStrb_t          strb;
  logic [PC_W-1:0]   pcQ;
  logic [CS_W-1:0]   csQ;
  logic [WORD_W-1:0] romWord;
  logic              selected;

  prog_seq_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .stateIdx (stateIdx),
    .strb     (strb)
  );

  prog_seq_data data_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctlBit (ctlBit),
    .strb   (strb),
    .pcQ    (pcQ),
    .csQ    (csQ)
  );

  assign romWord  = WORD_W'(int'(pcQ) * ROM_MULT + ROM_SEED);
  assign selected = (csQ == MY_CS);
  assign wordOut  = selected && (stateIdx < WORD_ST) && romWord[stateIdx];
  assign pcOut    = pcQ;
  assign csOut    = csQ;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |-> (pcOut == '0 && csOut == '0));
endmodule

// File: tb/prog_seq_tb.sv
module prog_seq_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] stateIdx;
  logic       ctlBit;
  logic       wordOut;
  logic [9:0] pcOut;
  logic [2:0] csOut;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [9:0] mPc;
  logic [2:0] mCs;

  always #5 clk = ~clk;

  prog_seq dut_i (
    .clk(clk), .rstN(rstN), .stateIdx(stateIdx), .ctlBit(ctlBit),
    .wordOut(wordOut), .pcOut(pcOut), .csOut(csOut)
  );

  // row: {load, cond, hold, addr[9:0], cs[2:0]} then expected {pc[9:0], cs[2:0]}
  localparam int ROWS = 14;
  localparam logic [28:0] TBL [ROWS] = '{
    {1'b1,1'b0,1'b0,10'h000,3'd0, 10'h000,3'd0},
    {1'b0,1'b0,1'b0,10'h000,3'd0, 10'h001,3'd0},
    {1'b0,1'b0,1'b1,10'h000,3'd0, 10'h001,3'd0},
    {1'b1,1'b0,1'b0,10'h3FE,3'd0, 10'h3FE,3'd0},
    {1'b0,1'b0,1'b0,10'h000,3'd0, 10'h3FF,3'd0},
    {1'b0,1'b0,1'b0,10'h000,3'd0, 10'h000,3'd0},
    {1'b1,1'b1,1'b0,10'h155,3'd0, 10'h001,3'd0},
    {1'b1,1'b0,1'b1,10'h2AA,3'd0, 10'h2AA,3'd0},
    {1'b1,1'b1,1'b1,10'h100,3'd0, 10'h2AA,3'd0},
    {1'b1,1'b0,1'b0,10'h0C3,3'd6, 10'h0C3,3'd6},
    {1'b0,1'b0,1'b0,10'h3FF,3'd7, 10'h0C4,3'd6},
    {1'b1,1'b0,1'b0,10'h000,3'd0, 10'h000,3'd0},
    {1'b1,1'b0,1'b0,10'h3A1,3'd0, 10'h3A1,3'd0},
    {1'b0,1'b0,1'b0,10'h000,3'd0, 10'h3A2,3'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] romW(input logic [9:0] a);
    return 13'(int'(a) * 37 + 'h0A5);
  endfunction

  function automatic string rowTag(input logic [15:0] st);
    if (st == 16'h8000)          return "R12";
    if (st[15] && !st[14])       return st[13] ? "R7" : "R3";
    if (st[15] && st[14])        return "R4";
    if (st[13])                  return "R5";
    return "R6";
  endfunction

  task automatic runFrame(input logic [15:0] st);
    for (int s = 0; s < 16; s++) begin
      logic expBit;
      @(negedge clk);
      stateIdx = 4'(s);
      if (s < 3)       ctlBit = st[15 - s];
      else if (s < 13) ctlBit = st[s];
      else             ctlBit = st[s - 13];
      #1;
      expBit = (mCs == 3'd0) && (s < 13) && romW(mPc)[s];
      chk(wordOut == expBit, (mCs == 3'd0) ? "R9 R11" : "R10", int'(wordOut), int'(expBit));
      if (s == 7) chk(pcOut == mPc && csOut == mCs, "R8", int'({pcOut, csOut}), int'({mPc, mCs}));
    end
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; stateIdx = '0; ctlBit = 1'b0;
    mPc = '0; mCs = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pcOut == 10'h000 && csOut == 3'd0, "R1", int'({pcOut, csOut}), 0);
    rstN = 1'b1;

    for (int r = 0; r < ROWS; r++) begin
      logic [15:0] st;
      logic [9:0]  ePc;
      logic [2:0]  eCs;
      st  = TBL[r][28:13];
      ePc = TBL[r][12:3];
      eCs = TBL[r][2:0];
      runFrame(st);
      chk(pcOut == ePc, rowTag(st), int'(pcOut), int'(ePc));
      // R2: chip-select bit order (value 6 is not symmetric)
      chk(csOut == eCs, "R2", int'(csOut), int'(eCs));
      mPc = ePc;
      mCs = eCs;
    end

    // R1: asynchronous reset in the middle of a cycle
    @(negedge clk);
    stateIdx = 4'd5; ctlBit = 1'b1;
    rstN = 1'b0;
    #1;
    chk(pcOut == 10'h000 && csOut == 3'd0, "R1", int'({pcOut, csOut}), 0);
    @(negedge clk);
    rstN = 1'b1;
    mPc = '0; mCs = '0;

    // R6: plain step after reset
    runFrame(16'h0000);
    chk(pcOut == 10'h001 && csOut == 3'd0, "R6", int'({pcOut, csOut}), int'({10'h001, 3'd0}));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule